// File: doc/BRIEF.md
# Carry-Free Redundant Binary Adder

This block adds two redundant binary (RB) numbers of `M` digits each and produces an `M+1`-digit RB sum, with no carry chain across the word. Every digit is one of -1, 0 or +1 and is held in two bits: a sign bit and a magnitude bit. Each position first splits its digit-pair total into a transfer digit, which goes one place up, and a local digit. It then adds the transfer digit that arrives from the position below. The transfer digit is chosen by looking at the pair one place lower, so the final digit always stays inside the digit set and the logic depth does not depend on `M`.

It serves as the basic cell of a partial-product reduction tree. The second operand can be taken either as an RB vector or as a sign-magnitude partial product. The sign-magnitude form becomes RB by pure wiring: the common sign bit is placed next to each magnitude bit. The sum also goes through a conversion stage that forms a positive-digit vector and a negative-digit vector and subtracts the second from the first, which gives the sum in two's complement. Both the RB sum and its two's-complement value are registered together, one cycle after the operands are presented.

Top module: `rb_cf_adder`

## Requirements
- R1: Digit i of any RB vector sits at bits [2i+1:2i], with bit 2i+1 the sign and bit 2i the magnitude. Code 01 is +1, code 11 is -1, and both 00 and 10 are zero.
- R2: The value of the `M+1`-digit RB sum equals the value of operand A plus the value of the selected second operand.
- R3: Digit M of the sum is the transfer out of the top position. When no operand digit is -1, that digit is never -1.
- R4: Sum digit i depends only on operand digits i, i-1 and i-2. Changing operand digits at positions j and above leaves sum digits below j unchanged.
- R5: With `pp_sel` high, the second operand is the sign-magnitude number (`pp_sign`, `pp_mag`), taken as digit i = {`pp_sign`, `pp_mag[i]`}. Its value is the magnitude, negated when `pp_sign` is 1.
- R6: With `pp_sel` low, `pp_sign` and `pp_mag` have no effect on either output.
- R7: `sum_tc` holds the value of `sum_rb` as an `M+2`-bit two's-complement number.
- R8: Both outputs update on the rising edge of `clk` that samples the operands, so the latency is one cycle.
- R9: While `rst_n` is low, both outputs are zero: every sum digit is 00 and `sum_tc` is 0.
- R10: With M=8, operand A = (-1,0,1,0,-1,1,1,0) and operand B = (0,0,1,-1,-1,1,1,1), listed most significant digit first (values -98 and 15), give a sum worth -83.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_rb | input | 2*M | Operand A in RB form |
| b_rb | input | 2*M | Operand B in RB form, used when `pp_sel` is low |
| pp_sel | input | 1 | Takes the second operand from the sign-magnitude inputs |
| pp_sign | input | 1 | Sign of the sign-magnitude operand (1 = negative) |
| pp_mag | input | M | Magnitude of the sign-magnitude operand |
| sum_rb | output | 2*(M+1) | Registered RB sum |
| sum_tc | output | M+2 | Registered two's-complement value of the sum |

## Verification
The bench builds two copies. The first uses M=8 and covers the worked example, the full-scale sums of plus and minus 510, the sign-magnitude path and tests of digit locality. The second uses M=3, which is small enough to apply every pair of 6-bit operand codes, including the redundant zero code, in 4096 cycles. That sweep covers every combination of digit-pair totals and lower-neighbour signs that the transfer selection can meet.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam logic [1:0] RB_ZERO = 2'b00;
    localparam logic [1:0] RB_POS  = 2'b01;
    localparam logic [1:0] RB_NEG  = 2'b11;

    function automatic logic rb_is_neg(input logic [1:0] d);
        return d[1] & d[0];
    endfunction

    function automatic logic signed [2:0] rb_val(input logic [1:0] d);
        if (!d[0])
            return 3'sd0;
        return d[1] ? -3'sd1 : 3'sd1;
    endfunction

    function automatic logic [1:0] rb_enc(input logic signed [2:0] v);
        logic [1:0] r;
        case (v)
            3'b001:  r = RB_POS;
            3'b111:  r = RB_NEG;
            default: r = RB_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rb_digit_cell.sv
module rb_digit_cell
    import rb_pkg::*;
(
    input  logic [1:0] a_dig,
    input  logic [1:0] b_dig,
    input  logic       low_neg,
    output logic [1:0] xfer,
    output logic [1:0] part
);

    logic signed [2:0] pair_sum;

    always_comb begin
        pair_sum = rb_val(a_dig) + rb_val(b_dig);
        xfer     = RB_ZERO;
        part     = RB_ZERO;
        case (pair_sum)
            3'b010: xfer = RB_POS;
            3'b110: xfer = RB_NEG;
            3'b001: begin
                if (low_neg) begin
                    part = RB_POS;
                end else begin
                    xfer = RB_POS;
                    part = RB_NEG;
                end
            end
            3'b111: begin
                if (low_neg) begin
                    xfer = RB_NEG;
                    part = RB_POS;
                end else begin
                    part = RB_NEG;
                end
            end
            default: begin
                xfer = RB_ZERO;
                part = RB_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/sm_to_rb.sv
module sm_to_rb #(
    parameter int M = 8
) (
    input  logic           sign,
    input  logic [M-1:0]   mag,
    output logic [2*M-1:0] rb
);

    for (genvar i = 0; i < M; i++) begin : g_pair
        assign rb[2*i+1 -: 2] = {sign, mag[i]};
    end

endmodule

// File: rtl/rb_to_twos.sv
module rb_to_twos #(
    parameter int DIGITS = 9
) (
    input  logic [2*DIGITS-1:0] rb,
    output logic [DIGITS:0]     tc
);

    logic [DIGITS-1:0] pos_vec;
    logic [DIGITS-1:0] neg_vec;

    for (genvar i = 0; i < DIGITS; i++) begin : g_split
        assign pos_vec[i] = rb[2*i] & ~rb[2*i+1];
        assign neg_vec[i] = rb[2*i] &  rb[2*i+1];
    end

    assign tc = {1'b0, pos_vec} - {1'b0, neg_vec};

endmodule

// File: rtl/rb_cf_adder.sv
module rb_cf_adder
    import rb_pkg::*;
#(
    parameter int M = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*M-1:0]       a_rb,
    input  logic [2*M-1:0]       b_rb,
    input  logic                 pp_sel,
    input  logic                 pp_sign,
    input  logic [M-1:0]         pp_mag,
    output logic [2*(M+1)-1:0]   sum_rb,
    output logic [M+1:0]         sum_tc
);

    localparam int W_IN  = 2 * M;
    localparam int W_SUM = 2 * (M + 1);
    localparam int W_TC  = M + 2;

    typedef struct packed {
        logic [W_SUM-1:0] sum;
        logic [W_TC-1:0]  tc;
    } out_t;

    out_t st_d, st_q;

    logic [W_IN-1:0]     pp_rb;
    logic [W_IN-1:0]     b_eff;
    logic [M-1:0]        low_neg;
    logic [M-1:0][1:0]   part_w;
    logic [M:0][1:0]     xfer_w;
    logic [W_SUM-1:0]    sum_comb;
    logic [W_TC-1:0]     tc_comb;

    sm_to_rb #(.M(M)) i_sm_to_rb (
        .sign (pp_sign),
        .mag  (pp_mag),
        .rb   (pp_rb)
    );

    assign b_eff     = pp_sel ? pp_rb : b_rb;
    assign xfer_w[0] = RB_ZERO;

    for (genvar i = 0; i < M; i++) begin : g_pos
        if (i == 0) begin : g_lsd
            assign low_neg[i] = 1'b0;
        end else begin : g_upper
            assign low_neg[i] = rb_is_neg(a_rb[2*i-1 -: 2]) | rb_is_neg(b_eff[2*i-1 -: 2]);
        end

        rb_digit_cell i_cell (
            .a_dig   (a_rb[2*i+1 -: 2]),
            .b_dig   (b_eff[2*i+1 -: 2]),
            .low_neg (low_neg[i]),
            .xfer    (xfer_w[i+1]),
            .part    (part_w[i])
        );
    end

    always_comb begin
        sum_comb = '0;
        for (int i = 0; i < M; i++) begin
            sum_comb[2*i+1 -: 2] = rb_enc(rb_val(part_w[i]) + rb_val(xfer_w[i]));
        end
        sum_comb[W_SUM-1 -: 2] = xfer_w[M];
    end

    rb_to_twos #(.DIGITS(M + 1)) i_rb_to_twos (
        .rb (sum_comb),
        .tc (tc_comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sum = sum_comb;
        st_d.tc  = tc_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_rb = st_q.sum;
    assign sum_tc = st_q.tc;

endmodule

// File: rtl/rb_cf_adder_chk.sv
module rb_cf_adder_chk #(
    parameter int M = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*M-1:0]       a_rb,
    input logic [2*M-1:0]       b_rb,
    input logic                 pp_sel,
    input logic                 pp_sign,
    input logic [M-1:0]         pp_mag,
    input logic [2*(M+1)-1:0]   sum_rb,
    input logic [M+1:0]         sum_tc
);

    function automatic int rbv(input logic [2*M+1:0] v, input int n);
        int acc;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            if (v[2*i+1 -: 2] == 2'b01) acc += (1 << i);
            if (v[2*i+1 -: 2] == 2'b11) acc -= (1 << i);
        end
        return acc;
    endfunction

    logic [2*M-1:0] b_sel;
    logic [2*M+3:0] a_pad;
    logic [2*M+3:0] b_pad;
    logic           no_neg;
    int             exp_val;

    always_comb begin
        no_neg = 1'b1;
        for (int i = 0; i < M; i++) begin
            b_sel[2*i+1 -: 2] = pp_sel ? {pp_sign, pp_mag[i]} : b_rb[2*i+1 -: 2];
        end
        for (int i = 0; i < M; i++) begin
            if (a_rb[2*i+1 -: 2] == 2'b11 || b_sel[2*i+1 -: 2] == 2'b11) no_neg = 1'b0;
        end
        exp_val = rbv({2'b00, a_rb}, M) + rbv({2'b00, b_sel}, M);
    end

    assign a_pad = {a_rb, 4'b0000};
    assign b_pad = {b_sel, 4'b0000};

    // R2, R8: sum value one cycle later matches the operand total
    a_r2_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rbv(sum_rb, M + 1) == $past(exp_val)));

    // R7: two's-complement output carries the same total
    a_r7_tc_value: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($signed(sum_tc) == $past(exp_val)));

    // R3: no negative operand digit means no negative top digit
    a_r3_top_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && no_neg) |=> (sum_rb[2*M+1 -: 2] != 2'b11));

    // R4: each sum digit sees only three operand positions
    for (genvar i = 0; i < M; i++) begin : g_loc
        a_r4_local: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && a_pad[2*i+5 -: 6] == $past(a_pad[2*i+5 -: 6])
                          && b_pad[2*i+5 -: 6] == $past(b_pad[2*i+5 -: 6]))
            |=> $stable(sum_rb[2*i+1 -: 2]));
    end

endmodule

bind rb_cf_adder rb_cf_adder_chk #(.M(M)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_rb    (a_rb),
    .b_rb    (b_rb),
    .pp_sel  (pp_sel),
    .pp_sign (pp_sign),
    .pp_mag  (pp_mag),
    .sum_rb  (sum_rb),
    .sum_tc  (sum_tc)
);

// File: tb/test_rb_cf_adder.sv
`timescale 1ns/1ps
module test_rb_cf_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a8 = '0, b8 = '0;
    logic        sel8 = 1'b0, sg8 = 1'b0;
    logic [7:0]  mag8 = '0;
    logic [17:0] s8;
    logic [9:0]  t8;
    logic [5:0]  a3 = '0, b3 = '0;
    logic        sg3 = 1'b0;
    logic [2:0]  mag3 = '0;
    logic [7:0]  s3;
    logic [4:0]  t3;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    rb_cf_adder #(.M(8)) i_rb_cf_adder (
        .clk(clk), .rst_n(rst_n), .a_rb(a8), .b_rb(b8), .pp_sel(sel8),
        .pp_sign(sg8), .pp_mag(mag8), .sum_rb(s8), .sum_tc(t8)
    );

    rb_cf_adder #(.M(3)) i_rb_cf_adder_small (
        .clk(clk), .rst_n(rst_n), .a_rb(a3), .b_rb(b3), .pp_sel(1'b0),
        .pp_sign(sg3), .pp_mag(mag3), .sum_rb(s3), .sum_tc(t3)
    );

    typedef struct {
        int    e8;
        int    e3;
        bit    nn;
        int    keep;
        string tag;
    } item_t;

    item_t q[$];

    function automatic int rbval(input logic [63:0] v, input int n);
        int acc = 0;
        for (int i = 0; i < n; i++) begin
            if (v[2*i+1 -: 2] == 2'b01) acc += (1 << i);
            if (v[2*i+1 -: 2] == 2'b11) acc -= (1 << i);
        end
        return acc;
    endfunction

    function automatic bit has_neg(input logic [15:0] v);
        for (int i = 0; i < 8; i++)
            if (v[2*i+1 -: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [15:0] rnd_nonneg();
        logic [15:0] r;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 3)
                0:       r[2*i+1 -: 2] = 2'b00;
                1:       r[2*i+1 -: 2] = 2'b01;
                default: r[2*i+1 -: 2] = 2'b10;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic s,
                         input logic g, input logic [7:0] m, input logic [5:0] sa,
                         input logic [5:0] sb, input int keep, input string tag);
        item_t it;
        @(negedge clk);
        a8 = a; b8 = b; sel8 = s; sg8 = g; mag8 = m;
        a3 = sa; b3 = sb; sg3 = 1'($urandom); mag3 = 3'($urandom);
        it.e8   = rbval({48'd0, a}, 8) + (s ? (g ? -int'(m) : int'(m)) : rbval({48'd0, b}, 8));
        it.e3   = rbval({58'd0, sa}, 3) + rbval({58'd0, sb}, 3);
        it.nn   = !has_neg(a) && (s ? !g : !has_neg(b));
        it.keep = keep;
        it.tag  = tag;
        q.push_back(it);
    endtask

    // monitor: pops one expected item per result cycle
    initial begin
        logic [17:0] prev8 = '0;
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                chk(rbval({46'd0, s8}, 9) == it.e8, "R2 R8 R6", it.tag, rbval({46'd0, s8}, 9), it.e8);
                chk($signed(t8) == it.e8, "R7", it.tag, $signed(t8), it.e8);
                chk(rbval({56'd0, s3}, 4) == it.e3, "R2 R1", {it.tag, " small"}, rbval({56'd0, s3}, 4), it.e3);
                chk($signed(t3) == it.e3, "R7", {it.tag, " small"}, $signed(t3), it.e3);
                if (it.nn)
                    chk(s8[17:16] != 2'b11, "R3", it.tag, int'(s8[17:16]), 1);
                if (it.keep > 0) begin
                    logic [17:0] msk;
                    msk = 18'((64'd1 << (2 * it.keep)) - 1);
                    chk((s8 & msk) == (prev8 & msk), "R4", it.tag, int'(s8 & msk), int'(prev8 & msk));
                end
                prev8 = s8;
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] base_a, base_b;
        // R9: operands present while reset is held
        a8 = 16'h5555; b8 = 16'h5555; a3 = 6'h15; b3 = 6'h15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(s8 == '0, "R9", "reset sum", int'(s8), 0);
        chk(t8 == '0, "R9", "reset tc", int'(t8), 0);
        chk(s3 == '0, "R9", "reset sum small", int'(s3), 0);
        chk(t3 == '0, "R9", "reset tc small", int'(t3), 0);
        rst_n = 1'b1;

        // R10 worked example: -98 + 15
        drive(16'b1100_0100_1101_0100, 16'b0000_0111_1101_0101, 1'b0, 1'b0, 8'h00, 6'h00, 6'h00, 0, "R10 worked");
        // R1: code 10 is zero
        drive(16'hAAAA, 16'h5555, 1'b0, 1'b0, 8'h00, 6'h2A, 6'h3F, 0, "R1 code10");
        drive(16'hFFFF, 16'hAAAA, 1'b0, 1'b0, 8'h00, 6'h2A, 6'h2A, 0, "R1 code10 neg");
        // R2 full scale
        drive(16'h5555, 16'h5555, 1'b0, 1'b0, 8'h00, 6'h15, 6'h15, 0, "R2 max");
        drive(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 8'h00, 6'h3F, 6'h3F, 0, "R2 min");
        // R5 sign-magnitude operand
        drive(16'h5555, 16'h0000, 1'b1, 1'b1, 8'hFF, 6'h00, 6'h00, 0, "R5 cancel");
        drive(16'h1D4F, 16'hFFFF, 1'b1, 1'b0, 8'hA5, 6'h01, 6'h30, 0, "R5 pos");
        drive(16'hFFFF, 16'h5555, 1'b1, 1'b1, 8'h00, 6'h00, 6'h00, 0, "R5 neg zero");
        for (int k = 0; k < 200; k++)
            drive(16'($urandom), 16'($urandom), 1'b1, 1'($urandom), 8'($urandom),
                  6'($urandom), 6'($urandom), 0, "R5 random");
        // R4 locality: keep low 5 digits, change the rest
        for (int k = 0; k < 100; k++) begin
            base_a = 16'($urandom); base_b = 16'($urandom);
            drive(base_a, base_b, 1'b0, 1'b0, 8'h00, 6'($urandom), 6'($urandom), 0, "R4 base");
            drive({6'($urandom), base_a[9:0]}, {6'($urandom), base_b[9:0]}, 1'b0, 1'b0, 8'h00,
                  6'($urandom), 6'($urandom), 5, "R4 upper change");
        end
        // R3 non-negative operands
        for (int k = 0; k < 300; k++)
            drive(rnd_nonneg(), rnd_nonneg(), 1'b0, 1'b0, 8'h00, 6'($urandom), 6'($urandom), 0, "R3 nonneg");
        // R6: pp inputs random while not selected
        for (int k = 0; k < 1500; k++)
            drive(16'($urandom), 16'($urandom), 1'b0, 1'($urandom), 8'($urandom),
                  6'($urandom), 6'($urandom), 0, "R6 random");
        // R2 exhaustive sweep of the small copy
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                drive(16'($urandom), 16'($urandom), 1'b0, 1'b0, 8'h00, 6'(i), 6'(j), 0, "R2 sweep");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule